// File: doc/BRIEF.md
# Boost-Gated Thread Priority Register

This block keeps the execution priority of one hardware thread as a 3-bit code inside a 64-bit special-purpose register. Next to it sits a 32-bit boost register. The highest priority that user code may request is allowed only while the boost register holds a nonzero value. Software reaches both registers through a move-to/move-from port. The port carries a register number, a write strobe with write data, and a read strobe with combinational read data.

Three register numbers are decoded:

- 896 is the full 64-bit priority register.
- 898 is a 32-bit view of that register's upper half.
- 159 is the boost register.

A priority write is screened before it is stored. Codes that are not user-settable are dropped, and so is the top code when the boost register is zero. In both cases the stored priority keeps its old value. Any other register number is reported on a one-cycle illegal flag, and the access has no effect.

Top module: `prio_spr_unit`

## Requirements
- R1: After reset the priority code is 100 (medium), so a read of register 896 returns 0x0010_0000_0000_0000. The boost register reads 0x0000_0100.
- R2: A write to register 896 takes the candidate code from write-data bits 52:50. Codes 001 to 100 are stored. Every register bit outside 52:50 is never stored and always reads as zero.
- R3: Code 101 is stored only while the boost register is nonzero. With the boost register at zero, a write of 101 leaves the stored code unchanged.
- R4: A candidate code of 000, 110 or 111 is refused, and the stored code keeps its previous value.
- R5: A read of register 898 returns register bits 63:32 in read-data bits 31:0, with read-data bits 63:32 zero. The code therefore appears at read-data bits 20:18.
- R6: A write to register 898 takes the candidate code from write-data bits 20:18. It is screened by the same rules as in R2, R3 and R4.
- R7: A write to register 159 stores write-data bits 31:0 unconditionally, and read-data bits 63:32 read as zero. A boost write never changes the priority code. Dropping the boost register to zero does not lower a code of 101 that is already stored.
- R8: A write takes effect on the rising clock edge at the end of its strobe cycle. A read in that same cycle returns the old value.
- R9: A read or write strobe with any other register number raises `bad_spr` in that cycle only, leaves both registers unchanged, and returns zero read data.
- R10: While `rd_en` is low, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| spr_num | input | 10 | Register number of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Read data, valid in the strobe cycle |
| bad_spr | output | 1 | Access to an undecoded register number |

## Verification
The bench builds the block with its default parameters:

- The code field sits at bits 52:50.
- The alias view is shifted by 32, which places the code at alias bits 20:18.
- The register numbers are 159, 896 and 898.
- The boost register resets to 0x100.

Because the boost reset value is nonzero, code 101 can be reached immediately after reset. The bench can then clear the boost register to exercise refusal and retention of 101. With these defaults, every candidate code can be driven through both the full view and the alias view, together with stray bits outside the field that must be discarded.

// File: rtl/prio_spr_pkg.sv
package prio_spr_pkg;

  // Which register an access selects
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_FULL  = 2'd1,
    SEL_HALF  = 2'd2,
    SEL_BOOST = 2'd3
  } spr_sel_e;

endpackage

// File: rtl/prio_rst_sync.sv
module prio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/prio_spr_decode.sv
module prio_spr_decode
  import prio_spr_pkg::*;
#(
  parameter int SPR_W     = 10,
  parameter int SPR_FULL  = 896,
  parameter int SPR_HALF  = 898,
  parameter int SPR_BOOST = 159
) (
  input  logic [SPR_W-1:0] spr_num,
  input  logic             wr_en,
  input  logic             rd_en,
  output spr_sel_e         sel,
  output logic             bad
);

  localparam logic [SPR_W-1:0] NUM_FULL  = SPR_W'(SPR_FULL);
  localparam logic [SPR_W-1:0] NUM_HALF  = SPR_W'(SPR_HALF);
  localparam logic [SPR_W-1:0] NUM_BOOST = SPR_W'(SPR_BOOST);

  always_comb begin
    if (spr_num == NUM_FULL)       sel = SEL_FULL;
    else if (spr_num == NUM_HALF)  sel = SEL_HALF;
    else if (spr_num == NUM_BOOST) sel = SEL_BOOST;
    else                           sel = SEL_NONE;
    bad = (wr_en | rd_en) & (sel == SEL_NONE);
  end

endmodule

// File: rtl/prio_field_reg.sv
module prio_field_reg
  import prio_spr_pkg::*;
#(
  parameter int FIELD_W    = 3,
  parameter int RST_CODE   = 4,
  parameter int BASE_MAX   = 4,
  parameter int BOOST_CODE = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  spr_sel_e           sel,
  input  logic [FIELD_W-1:0] cand_full,
  input  logic [FIELD_W-1:0] cand_half,
  input  logic               boost_nz,
  output logic [FIELD_W-1:0] prio_q
);

  localparam logic [FIELD_W-1:0] CODE_RST   = FIELD_W'(RST_CODE);
  localparam logic [FIELD_W-1:0] CODE_MAX   = FIELD_W'(BASE_MAX);
  localparam logic [FIELD_W-1:0] CODE_BOOST = FIELD_W'(BOOST_CODE);

  logic [FIELD_W-1:0] cand;
  logic               base_ok;
  logic               boost_ok;
  logic               load;
  logic [FIELD_W-1:0] prio_d;

  always_comb begin
    cand     = (sel == SEL_HALF) ? cand_half : cand_full;
    base_ok  = (cand != '0) && (cand <= CODE_MAX);
    boost_ok = (cand == CODE_BOOST) && boost_nz;
    load     = wr_en && ((sel == SEL_FULL) || (sel == SEL_HALF)) &&
               (base_ok || boost_ok);
    prio_d   = cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prio_q <= CODE_RST;
    else if (load) prio_q <= prio_d;
  end

endmodule

// File: rtl/prio_boost_reg.sv
module prio_boost_reg
  import prio_spr_pkg::*;
#(
  parameter int BOOST_W   = 32,
  parameter int RST_BOOST = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  spr_sel_e           sel,
  input  logic [BOOST_W-1:0] wdata,
  output logic [BOOST_W-1:0] boost_q,
  output logic               boost_nz
);

  logic               load;
  logic [BOOST_W-1:0] boost_d;

  always_comb begin
    load    = wr_en && (sel == SEL_BOOST);
    boost_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    boost_q <= BOOST_W'(RST_BOOST);
    else if (load) boost_q <= boost_d;
  end

  assign boost_nz = |boost_q;

endmodule

// File: rtl/prio_spr_unit.sv
module prio_spr_unit
  import prio_spr_pkg::*;
#(
  parameter int SPR_W       = 10,
  parameter int DATA_W      = 64,
  parameter int BOOST_W     = 32,
  parameter int FIELD_W     = 3,
  parameter int FIELD_LSB   = 50,
  parameter int ALIAS_SHIFT = 32,
  parameter int SPR_FULL    = 896,
  parameter int SPR_HALF    = 898,
  parameter int SPR_BOOST   = 159,
  parameter int RST_CODE    = 4,
  parameter int BASE_MAX    = 4,
  parameter int BOOST_CODE  = 5,
  parameter int RST_BOOST   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPR_W-1:0]  spr_num,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              bad_spr
);

  localparam int HALF_W   = DATA_W - ALIAS_SHIFT;
  localparam int HALF_LSB = FIELD_LSB - ALIAS_SHIFT;

  logic               rst_sync_n;
  spr_sel_e           sel;
  logic [FIELD_W-1:0] prio_q;
  logic [BOOST_W-1:0] boost_q;
  logic               boost_nz;
  logic [DATA_W-1:0]  full_view;

  prio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  prio_spr_decode #(
    .SPR_W(SPR_W), .SPR_FULL(SPR_FULL), .SPR_HALF(SPR_HALF), .SPR_BOOST(SPR_BOOST)
  ) u_dec (
    .spr_num (spr_num),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .sel     (sel),
    .bad     (bad_spr)
  );

  prio_field_reg #(
    .FIELD_W(FIELD_W), .RST_CODE(RST_CODE), .BASE_MAX(BASE_MAX), .BOOST_CODE(BOOST_CODE)
  ) u_field (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .sel       (sel),
    .cand_full (wr_data[FIELD_LSB +: FIELD_W]),
    .cand_half (wr_data[HALF_LSB +: FIELD_W]),
    .boost_nz  (boost_nz),
    .prio_q    (prio_q)
  );

  prio_boost_reg #(.BOOST_W(BOOST_W), .RST_BOOST(RST_BOOST)) u_boost (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .sel      (sel),
    .wdata    (wr_data[BOOST_W-1:0]),
    .boost_q  (boost_q),
    .boost_nz (boost_nz)
  );

  // Register image: only the code field is backed by storage
  always_comb begin
    full_view = '0;
    full_view[FIELD_LSB +: FIELD_W] = prio_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (sel)
        SEL_FULL:  rd_data = full_view;
        SEL_HALF:  rd_data = {{(DATA_W-HALF_W){1'b0}}, full_view[DATA_W-1 -: HALF_W]};
        SEL_BOOST: rd_data = {{(DATA_W-BOOST_W){1'b0}}, boost_q};
        default:   rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/prio_spr_checker.sv
module prio_spr_checker #(
  parameter int SPR_W      = 10,
  parameter int DATA_W     = 64,
  parameter int BOOST_W    = 32,
  parameter int FIELD_W    = 3,
  parameter int FIELD_LSB  = 50,
  parameter int SPR_FULL   = 896,
  parameter int SPR_BOOST  = 159,
  parameter int BASE_MAX   = 4,
  parameter int BOOST_CODE = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SPR_W-1:0]   spr_num,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wr_data,
  input logic               rd_en,
  input logic [DATA_W-1:0]  rd_data,
  input logic               bad_spr,
  input logic [FIELD_W-1:0] prio_q,
  input logic [BOOST_W-1:0] boost_q
);

  localparam logic [DATA_W-1:0] FIELD_MASK = {{(DATA_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << FIELD_LSB;

  assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q != '0) && (int'(prio_q) <= BOOST_CODE));

  assert_gate_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && spr_num == SPR_W'(SPR_FULL) && boost_q == '0 &&
     int'(wr_data[FIELD_LSB +: FIELD_W]) == BOOST_CODE) |=> $stable(prio_q));

  assert_full_read_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && spr_num == SPR_W'(SPR_FULL)) |-> ((rd_data & ~FIELD_MASK) == '0));

  assert_boost_keeps_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && spr_num == SPR_W'(SPR_BOOST)) |=> $stable(prio_q));

  assert_bad_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_spr |=> ($stable(prio_q) && $stable(boost_q)));

  assert_bad_zero_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_spr |-> (rd_data == '0));

  assert_bad_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_spr |-> (rd_en || wr_en));

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

endmodule

bind prio_spr_unit prio_spr_checker #(
  .SPR_W(SPR_W), .DATA_W(DATA_W), .BOOST_W(BOOST_W), .FIELD_W(FIELD_W),
  .FIELD_LSB(FIELD_LSB), .SPR_FULL(SPR_FULL), .SPR_BOOST(SPR_BOOST),
  .BASE_MAX(BASE_MAX), .BOOST_CODE(BOOST_CODE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .spr_num (spr_num),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .bad_spr (bad_spr),
  .prio_q  (prio_q),
  .boost_q (boost_q)
);

// File: tb/prio_spr_unit_tb.sv
module prio_spr_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] N_FULL  = 10'd896;
  localparam logic [9:0] N_HALF  = 10'd898;
  localparam logic [9:0] N_BOOST = 10'd159;

  logic        clk;
  logic        rst_n;
  logic [9:0]  spr_num;
  logic        wr_en;
  logic [63:0] wr_data;
  logic        rd_en;
  logic [63:0] rd_data;
  logic        bad_spr;

  int checks = 0;
  int fails  = 0;

  prio_spr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .spr_num(spr_num), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .bad_spr(bad_spr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] full_img(input logic [2:0] c);
    return {11'd0, c, 50'd0};
  endfunction

  function automatic logic [63:0] half_img(input logic [2:0] c);
    return {43'd0, c, 18'd0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  task automatic idle();
    spr_num = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_write(input logic [9:0] n, input logic [63:0] d);
    @(negedge clk);
    spr_num = n; wr_en = 1'b1; rd_en = 1'b0; wr_data = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_read(input logic [9:0] n, output logic [63:0] d, output logic b);
    @(negedge clk);
    spr_num = n; rd_en = 1'b1; wr_en = 1'b0;
    #1;
    d = rd_data; b = bad_spr;
    @(negedge clk);
    idle();
  endtask

  task automatic expect_code(input string req, input logic [2:0] c);
    logic [63:0] d; logic b;
    do_read(N_FULL, d, b);
    chk(req, d, full_img(c));
  endtask

  task automatic t_reset();
    logic [63:0] d; logic b;
    expect_code("R1 reset code", 3'd4);
    do_read(N_BOOST, d, b);
    chk("R1 reset boost", d, 64'h100);
  endtask

  task automatic t_full_writes();
    for (int c = 1; c <= 4; c++) begin
      do_write(N_FULL, 64'hFFE3_FFFF_FFFF_FFFF | full_img(3'(c)));
      expect_code("R2 full write", 3'(c));
    end
  endtask

  task automatic t_invalid();
    do_write(N_FULL, full_img(3'd2));
    do_write(N_FULL, full_img(3'd0));
    expect_code("R4 code 000 refused", 3'd2);
    do_write(N_FULL, full_img(3'd6));
    expect_code("R4 code 110 refused", 3'd2);
    do_write(N_FULL, full_img(3'd7));
    expect_code("R4 code 111 refused", 3'd2);
  endtask

  task automatic t_gate();
    logic [63:0] d; logic b;
    do_write(N_BOOST, 64'hFFFF_FFFF_0000_0000);
    do_read(N_BOOST, d, b);
    chk("R7 boost stores low half", d, 64'h0);
    expect_code("R7 boost write keeps code", 3'd2);
    do_write(N_FULL, full_img(3'd5));
    expect_code("R3 101 refused at zero boost", 3'd2);
    do_write(N_BOOST, 64'h7);
    do_write(N_FULL, full_img(3'd5));
    expect_code("R3 101 accepted with boost", 3'd5);
    do_write(N_BOOST, 64'h0);
    expect_code("R7 101 kept after boost cleared", 3'd5);
  endtask

  task automatic t_alias();
    logic [63:0] d; logic b;
    do_read(N_HALF, d, b);
    chk("R5 alias read", d, half_img(3'd5));
    do_write(N_HALF, 64'hFFFF_FFFF_FFE3_FFFF | half_img(3'd3));
    expect_code("R6 alias write", 3'd3);
    do_read(N_HALF, d, b);
    chk("R5 alias read after write", d, half_img(3'd3));
    do_write(N_HALF, half_img(3'd0));
    expect_code("R6 alias invalid refused", 3'd3);
    do_write(N_HALF, half_img(3'd5));
    expect_code("R6 alias 101 refused at zero boost", 3'd3);
    do_write(N_BOOST, 64'h1);
    do_write(N_HALF, half_img(3'd5));
    expect_code("R6 alias 101 with boost", 3'd5);
  endtask

  task automatic t_timing();
    @(negedge clk);
    spr_num = N_FULL; wr_en = 1'b1; rd_en = 1'b1; wr_data = full_img(3'd1);
    #1;
    chk("R8 same-cycle read old", rd_data, full_img(3'd5));
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R8 new value next cycle", rd_data, full_img(3'd1));
    idle();
  endtask

  task automatic t_illegal();
    logic [63:0] d; logic b;
    do_read(10'd897, d, b);
    chk("R9 bad read flag", {63'd0, b}, 64'd1);
    chk("R9 bad read data", d, 64'd0);
    @(negedge clk);
    spr_num = 10'd158; wr_en = 1'b1; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    #1;
    chk("R9 bad write flag", {63'd0, bad_spr}, 64'd1);
    @(negedge clk);
    idle();
    #1;
    chk("R9 flag drops", {63'd0, bad_spr}, 64'd0);
    expect_code("R9 code unchanged", 3'd1);
    do_read(N_BOOST, d, b);
    chk("R9 boost unchanged", d, 64'h1);
    chk("R9 legal access no flag", {63'd0, b}, 64'd0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    spr_num = N_FULL; rd_en = 1'b0; wr_en = 1'b0;
    #1;
    chk("R10 idle read zero", rd_data, 64'd0);
    idle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_writes();
    t_invalid();
    t_gate();
    t_alias();
    t_timing();
    t_illegal();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule